// File: doc/BRIEF.md
# Page Fault Error Code Encoder

This block turns the outcome of an address translation into the fault record that the exception unit consumes. Each request carries the virtual address, the paging mode (long mode and five-level paging), whether the translation reported a fault and of which class, the access type, the privilege level, and the no-execute and supervisor-execute-prevention enables.

The block first checks that the address is canonical. A non-canonical address in long mode becomes a general-protection fault. Otherwise a reported translation fault becomes a page fault with a composed error code.

The record is registered once. It appears one clock after the request, together with a valid strobe, and it holds its value between requests. Raising the exception and handling virtualization exits belong to other blocks.

Top module: `pf_code_enc`

## Requirements
- R1: After reset, out_valid, out_fault, out_vector, out_code and out_addr are all zero. Each request accepted with req_valid high gives out_valid high and its record exactly one clock later.
- R2: With req_long high and req_five_level low, address bits 63 down to 47 must all be equal. If they are not, the record is a general-protection fault: out_fault 1, out_vector 13, out_code 0 and out_addr equal to the address. This holds whatever req_fault says. With req_long low, no canonical check is made.
- R3: With req_long and req_five_level both high, only address bits 63 down to 56 must all be equal. A failure gives the same general-protection record as in R2.
- R4: A canonical request with req_fault high gives out_fault 1, out_vector 14 and out_addr equal to the address. The class code 0 (not present) starts from an error code of zero.
- R5: Class code 1 (reserved bit) sets error-code bit 3. Class code 2 (protection) sets error-code bit 0.
- R6: Class code 3 (key protection) sets error-code bits 5 and 0. On a fetch it is reported as a plain protection fault: bit 0 only, and bit 5 stays clear.
- R7: Error-code bit 2 is set when req_user is high. Bit 1 is set for a store. The access codes are 0 load, 1 store, 2 fetch, and 3 counts as a load.
- R8: Error-code bit 4 is set on a fetch only when req_nxe or req_smep is high.
- R9: A canonical request with req_fault low gives out_fault 0, out_vector 0, out_code 0 and out_addr 0.
- R10: In a cycle with req_valid low, out_valid falls to 0 one clock later. The record outputs keep their previous values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is expected to be synchronous |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_long | input | 1 | Long-mode paging active |
| req_five_level | input | 1 | Five-level paging active |
| req_fault | input | 1 | Translation reported a fault |
| req_class | input | 2 | Fault class: 0 not present, 1 reserved bit, 2 protection, 3 key |
| req_access | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | User-mode access |
| req_nxe | input | 1 | No-execute enable |
| req_smep | input | 1 | Supervisor execute prevention enable |
| out_valid | output | 1 | Record valid, one cycle after the request |
| out_fault | output | 1 | Record describes a fault |
| out_vector | output | 8 | Exception number (13 or 14, 0 when no fault) |
| out_code | output | CODE_W | Error code |
| out_addr | output | VA_W | Faulting address |

## Verification
Every result of this block is due exactly one clock after its request, because a single register stage sits between the inputs and the record. The bench drives each request on a falling edge and compares all record fields on the next falling edge, which comes after the one rising edge that captures the request. For the hold checks of R10, the bench drives idle cycles with scrambled inputs. It then compares the record, one falling edge later, against the expected record of the last accepted request.

// File: rtl/pf_code_enc_pkg.sv
`timescale 1ns/1ps
package pf_code_enc_pkg;
  typedef enum logic [1:0] {
    CLS_ABSENT = 2'd0,
    CLS_RSVD   = 2'd1,
    CLS_PROT   = 2'd2,
    CLS_KEY    = 2'd3
  } fault_cls_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_RSVD    = 3;
  localparam int BIT_FETCH   = 4;
  localparam int BIT_KEY     = 5;
  localparam int MIN_CODE_W  = 6;

  localparam logic [7:0] VEC_GENPROT = 8'd13;
  localparam logic [7:0] VEC_PAGE    = 8'd14;
endpackage

// File: rtl/pf_canon_chk.sv
`timescale 1ns/1ps
module pf_canon_chk #(
  parameter int VA_W  = 64,
  parameter int LO_L4 = 47,
  parameter int LO_L5 = 56
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            long_mode,
  input  logic            five_level,
  output logic            noncanon
);
  localparam int HI_L4 = VA_W - LO_L4;
  localparam int HI_L5 = VA_W - LO_L5;

  logic [HI_L4-1:0] top_l4;
  logic [HI_L5-1:0] top_l5;
  logic             ok_l4;
  logic             ok_l5;

  always_comb begin
    top_l4 = vaddr[VA_W-1:LO_L4];
    top_l5 = vaddr[VA_W-1:LO_L5];
    ok_l4  = (&top_l4) | ~(|top_l4);
    ok_l5  = (&top_l5) | ~(|top_l5);
    if (!long_mode) begin
      noncanon = 1'b0;
    end else if (five_level) begin
      noncanon = ~ok_l5;
    end else begin
      noncanon = ~ok_l4;
    end
  end
endmodule

// File: rtl/pf_code_build.sv
`timescale 1ns/1ps
module pf_code_build
  import pf_code_enc_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic [1:0]        cls,
  input  logic [1:0]        acc,
  input  logic              user,
  input  logic              nxe,
  input  logic              smep,
  output logic [CODE_W-1:0] code
);
  fault_cls_e c_kind;
  acc_kind_e  a_kind;
  logic       is_fetch;
  logic       is_store;

  always_comb begin
    c_kind   = fault_cls_e'(cls);
    a_kind   = acc_kind_e'(acc);
    is_fetch = (a_kind == ACC_FETCH);
    is_store = (a_kind == ACC_STORE);
    code     = '0;
    unique case (c_kind)
      CLS_ABSENT: ;
      CLS_RSVD:   code[BIT_RSVD] = 1'b1;
      CLS_PROT:   code[BIT_PRESENT] = 1'b1;
      CLS_KEY: begin
        code[BIT_PRESENT] = 1'b1;
        code[BIT_KEY]     = ~is_fetch;
      end
      default: ;
    endcase
    code[BIT_USER]  = user;
    code[BIT_WRITE] = is_store;
    code[BIT_FETCH] = is_fetch & (nxe | smep);
  end
endmodule

// File: rtl/pf_code_enc.sv
`timescale 1ns/1ps
module pf_code_enc
  import pf_code_enc_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_long,
  input  logic              req_five_level,
  input  logic              req_fault,
  input  logic [1:0]        req_class,
  input  logic [1:0]        req_access,
  input  logic              req_user,
  input  logic              req_nxe,
  input  logic              req_smep,
  output logic              out_valid,
  output logic              out_fault,
  output logic [7:0]        out_vector,
  output logic [CODE_W-1:0] out_code,
  output logic [VA_W-1:0]   out_addr
);
  localparam int LO_L4 = 47;
  localparam int LO_L5 = 56;

  logic              noncanon;
  logic [CODE_W-1:0] pf_code;

  logic              nx_fault;
  logic [7:0]        nx_vector;
  logic [CODE_W-1:0] nx_code;
  logic [VA_W-1:0]   nx_addr;
  logic              rec_en;

  pf_canon_chk #(
    .VA_W  (VA_W),
    .LO_L4 (LO_L4),
    .LO_L5 (LO_L5)
  ) u_canon (
    .vaddr      (req_vaddr),
    .long_mode  (req_long),
    .five_level (req_five_level),
    .noncanon   (noncanon)
  );

  pf_code_build #(
    .CODE_W (CODE_W)
  ) u_build (
    .cls  (req_class),
    .acc  (req_access),
    .user (req_user),
    .nxe  (req_nxe),
    .smep (req_smep),
    .code (pf_code)
  );

  // next-state of the record
  always_comb begin
    rec_en    = req_valid;
    nx_fault  = 1'b0;
    nx_vector = '0;
    nx_code   = '0;
    nx_addr   = '0;
    if (noncanon) begin
      nx_fault  = 1'b1;
      nx_vector = VEC_GENPROT;
      nx_addr   = req_vaddr;
    end else if (req_fault) begin
      nx_fault  = 1'b1;
      nx_vector = VEC_PAGE;
      nx_code   = pf_code;
      nx_addr   = req_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_fault  <= 1'b0;
      out_vector <= '0;
      out_code   <= '0;
      out_addr   <= '0;
    end else if (rec_en) begin
      out_fault  <= nx_fault;
      out_vector <= nx_vector;
      out_code   <= nx_code;
      out_addr   <= nx_addr;
    end
  end
endmodule

// File: rtl/pf_code_enc_chk.sv
`timescale 1ns/1ps
module pf_code_enc_chk #(
  parameter int VA_W   = 64,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_long,
  input logic              req_fault,
  input logic [1:0]        req_class,
  input logic [1:0]        req_access,
  input logic              req_nxe,
  input logic              req_smep,
  input logic              out_valid,
  input logic              out_fault,
  input logic [7:0]        out_vector,
  input logic [CODE_W-1:0] out_code,
  input logic [VA_W-1:0]   out_addr
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_gp_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_vector == 8'd13) |-> (out_code == '0 && out_fault));

  assert_flat_page_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long && req_fault) |=> (out_fault && out_vector == 8'd14));

  assert_key_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long && req_fault && req_class == 2'd3 && req_access != 2'd2)
      |=> (out_code[5] && out_code[0]));

  assert_key_never_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_code[5] |-> !out_code[4]);

  assert_fetch_bit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_access == 2'd2 && !req_nxe && !req_smep) |=> !out_code[4]);

  assert_no_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long && !req_fault) |=> (!out_fault && out_code == '0 && out_addr == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_code) && $stable(out_addr) && $stable(out_vector)));
endmodule

bind pf_code_enc pf_code_enc_chk #(
  .VA_W   (VA_W),
  .CODE_W (CODE_W)
) u_pf_code_enc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_long   (req_long),
  .req_fault  (req_fault),
  .req_class  (req_class),
  .req_access (req_access),
  .req_nxe    (req_nxe),
  .req_smep   (req_smep),
  .out_valid  (out_valid),
  .out_fault  (out_fault),
  .out_vector (out_vector),
  .out_code   (out_code),
  .out_addr   (out_addr)
);

// File: tb/test_pf_code_enc.sv
`timescale 1ns/1ps
module test_pf_code_enc;
  localparam int VA_W   = 64;
  localparam int CODE_W = 16;
  localparam int RW     = 1 + 8 + CODE_W + VA_W;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [VA_W-1:0]   req_vaddr;
  logic              req_long;
  logic              req_five_level;
  logic              req_fault;
  logic [1:0]        req_class;
  logic [1:0]        req_access;
  logic              req_user;
  logic              req_nxe;
  logic              req_smep;
  logic              out_valid;
  logic              out_fault;
  logic [7:0]        out_vector;
  logic [CODE_W-1:0] out_code;
  logic [VA_W-1:0]   out_addr;

  int n_run;
  int n_fail;
  bit done;
  logic [RW-1:0] last_exp;

  pf_code_enc #(.VA_W(VA_W), .CODE_W(CODE_W)) i_pf_code_enc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_long(req_long), .req_five_level(req_five_level), .req_fault(req_fault),
    .req_class(req_class), .req_access(req_access), .req_user(req_user),
    .req_nxe(req_nxe), .req_smep(req_smep), .out_valid(out_valid),
    .out_fault(out_fault), .out_vector(out_vector), .out_code(out_code),
    .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected record {fault, vector, code, addr} from the requirements
  function automatic logic [RW-1:0] model(
    input logic [VA_W-1:0] va, input logic lm, input logic l5, input logic flt,
    input logic [1:0] cls, input logic [1:0] acc, input logic usr,
    input logic nx, input logic sm);
    logic [CODE_W-1:0] c;
    longint sx;
    bit canon;
    sx = $signed(va) >>> (l5 ? 56 : 47);
    canon = !lm || sx == 0 || sx == -1;
    c = '0;
    if (!canon) return {1'b1, 8'd13, {CODE_W{1'b0}}, va};      // R2 R3
    if (!flt) return '0;                                          // R9
    if (cls == 2'd1) c[3] = 1'b1;                                 // R5
    if (cls == 2'd2) c[0] = 1'b1;                                 // R5
    if (cls == 2'd3) begin c[0] = 1'b1; c[5] = (acc != 2'd2); end // R6
    if (usr) c[2] = 1'b1;                                         // R7
    if (acc == 2'd1) c[1] = 1'b1;                                 // R7
    if (acc == 2'd2 && (nx || sm)) c[4] = 1'b1;                   // R8
    return {1'b1, 8'd14, c, va};                                  // R4
  endfunction

  task automatic check(input string req, input logic [RW-1:0] exp, input logic ev);
    n_run++;
    if ({out_fault, out_vector, out_code, out_addr} !== exp || out_valid !== ev) begin
      n_fail++;
      $display("FAIL %s: got v=%0b f=%0b vec=%0d code=%h addr=%h, exp v=%0b f=%0b vec=%0d code=%h addr=%h",
               req, out_valid, out_fault, out_vector, out_code, out_addr,
               ev, exp[RW-1], exp[RW-2 -: 8], exp[VA_W +: CODE_W], exp[VA_W-1:0]);
    end
  endtask

  task automatic send(input string req, input logic [VA_W-1:0] va, input logic lm,
                      input logic l5, input logic flt, input logic [1:0] cls,
                      input logic [1:0] acc, input logic usr, input logic nx,
                      input logic sm);
    req_valid = 1'b1; req_vaddr = va; req_long = lm; req_five_level = l5;
    req_fault = flt; req_class = cls; req_access = acc; req_user = usr;
    req_nxe = nx; req_smep = sm;
    last_exp = model(va, lm, l5, flt, cls, acc, usr, nx, sm);
    @(negedge clk);
    check(req, last_exp, 1'b1);
  endtask

  task automatic idle(input string req);
    req_valid = 1'b0;
    req_vaddr = {$urandom, $urandom}; req_long = 1'b1; req_five_level = 1'b0;
    req_fault = 1'b1; req_class = 2'($urandom); req_access = 2'($urandom);
    req_user = 1'b1; req_nxe = 1'b1; req_smep = 1'b1;
    @(negedge clk);
    check(req, last_exp, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end, exp end of run");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VA_W-1:0] va;
    void'($urandom(32'h5eed_0e1));
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_long = 1'b0;
    req_five_level = 1'b0; req_fault = 1'b0; req_class = '0; req_access = '0;
    req_user = 1'b0; req_nxe = 1'b0; req_smep = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    send("R2 edge canonical high", 64'hFFFF_8000_0000_0000, 1, 0, 0, 0, 0, 0, 0, 0);
    send("R2 bit47 only set",      64'h0000_8000_0000_0000, 1, 0, 1, 2, 1, 1, 1, 1);
    send("R2 no check outside long", 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R3 five-level accepts",  64'h00FF_8000_0000_1000, 1, 1, 1, 0, 0, 0, 0, 0);
    send("R3 five-level rejects",  64'h0100_0000_0000_1000, 1, 1, 0, 0, 0, 0, 0, 0);
    send("R4 not present zero",    64'h0000_0000_0040_1000, 1, 0, 1, 0, 0, 0, 0, 0);
    send("R5 reserved bit",        64'h0000_0000_0040_2000, 1, 0, 1, 1, 0, 0, 0, 0);
    send("R5 protection bit",      64'h0000_0000_0040_3000, 0, 0, 1, 2, 0, 0, 0, 0);
    send("R6 key on store",        64'h0000_0000_0040_4000, 0, 0, 1, 3, 1, 1, 0, 0);
    send("R6 key on fetch",        64'h0000_0000_0040_5000, 0, 0, 1, 3, 2, 0, 1, 0);
    send("R7 user store",          64'h0000_0000_0040_6000, 0, 0, 1, 0, 1, 1, 0, 0);
    send("R7 access code 3 as load", 64'h0000_0000_0040_7000, 0, 0, 1, 0, 3, 0, 1, 1);
    send("R8 fetch no enables",    64'h0000_0000_0040_8000, 0, 0, 1, 2, 2, 0, 0, 0);
    send("R8 fetch smep only",     64'h0000_0000_0040_9000, 0, 0, 1, 2, 2, 0, 0, 1);
    send("R9 clean result",        64'h0000_0000_0040_A000, 1, 0, 0, 3, 1, 1, 1, 1);
    send("R2 gp with fault flag",  64'h8000_0000_0000_0000, 1, 0, 1, 3, 1, 1, 1, 1);
    idle("R10 hold after gp");
    idle("R10 hold second idle");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      va = {$urandom, $urandom};
      case ($urandom % 4)
        0: va[63:47] = '0;
        1: va[63:47] = '1;
        2: ;
        default: begin va[63:56] = '0; va[50] = 1'b1; end
      endcase
      send("R4 R5 R6 R7 R8 random", va, 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 5 == 0) idle("R10 random idle");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule